// File: doc/BRIEF.md
# Line Transceiver Direction Controller

This block sits next to a 16550-class UART and decides, cycle by cycle, when an external line transceiver may drive the line and when it may listen. It has a small byte-wide register port. Through that port software picks one of four wire modes, sets a master enable and a termination enable, and reads back two things: the port's fixed capabilities and the depths of the UART FIFOs.

The UART supplies two inputs: its DTR output and a busy flag. The busy flag is high while the TX FIFO holds data or the shifter is still sending, up to and including the last stop bit. In the half-duplex modes the driver is keyed either by DTR or by the busy flag. The receiver is blanked while the driver is on and for one further cycle after it drops, so the line settles before listening starts again. When the port runs as RS-232, or in full-duplex mode, both directions stay open whenever the master enable is set.

The transmit-enable and receive-enable outputs are combinational from the inputs and registered state. A change on `tx_busy` or `dtr` therefore reaches the driver in the same cycle. A register write takes effect from the next cycle.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: After reset, `tx_en`, `rx_en` and `term_en` are 0. The control register at offset 0xF reads 0x03, which is automatic mode with the master enable off.
- R2: In wire mode 0 (full duplex) with the master enable set, `tx_en` and `rx_en` are both 1 whatever `dtr` and `tx_busy` are.
- R3: In wire mode 1 (two-wire with echo) with the master enable set, `tx_en` follows `dtr` and `rx_en` stays 1.
- R4: In wire mode 2 (two-wire, DTR keyed) with the master enable set, `tx_en` follows `dtr`. `rx_en` is 0 while `tx_en` is 1 and in the cycle after `tx_en` falls.
- R5: In wire mode 3 (two-wire automatic) with the master enable set, `tx_en` equals `tx_busy` in the same cycle. `rx_en` is 0 while `tx_en` is 1 and in the one cycle after it falls, then returns to 1.
- R6: While control bit 3 (master enable) is 0, `tx_en` and `rx_en` are both 0 in every mode.
- R7: `term_en` equals control bit 6.
- R8: Offset 0xE reads the capability parameter in bits [1:0] and the interface mode in bit 4 (0 means RS-232, 1 means RS-485). Writes never change bits [1:0]. Bit 4 is writable only when the capability is 3 (dual), and it resets to 1 in that case.
- R9: Offsets 0xC and 0xD read the TX and RX FIFO depth parameters as bytes. Writes to them are ignored. Offsets with no register read 0x00.
- R10: When the interface mode bit is 0 (RS-232) and the master enable is set, `tx_en` and `rx_en` are both 1 whatever the wire mode is.
- R11: The control register holds only bits [1:0], 3 and 6. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| dtr | input | 1 | DTR from the UART |
| tx_busy | input | 1 | UART has data pending or is still shifting |
| tx_en | output | 1 | Transceiver driver enable |
| rx_en | output | 1 | Transceiver receiver enable |
| term_en | output | 1 | Line termination enable |

## Verification
Two events can land in the same cycle: a control write that changes the wire mode, and the busy flag falling at the end of a frame. The bench provokes this in automatic mode. While the driver is still on, it lowers `tx_busy` and writes DTR-keyed mode with `dtr` low, both in the same cycle. In that cycle the driver must drop under the old mode and the receiver must stay blanked. In the next cycle the new mode is in force and the receiver must come back. Each expectation is queued by the driver task and compared by the monitor in the cycle it names.

// File: rtl/xcvr_dir_pkg.sv
package xcvr_dir_pkg;

    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] OFS_TXSZ = 4'hC;
    localparam logic [AW-1:0] OFS_RXSZ = 4'hD;
    localparam logic [AW-1:0] OFS_MODE = 4'hE;
    localparam logic [AW-1:0] OFS_CTRL = 4'hF;

    typedef enum logic [1:0] {
        WM_FULL = 2'd0,
        WM_ECHO = 2'd1,
        WM_DTR  = 2'd2,
        WM_AUTO = 2'd3
    } wire_mode_e;

    typedef struct packed {
        wire_mode_e mode;
        logic       master;
        logic       term;
        logic       iface;   // 1 = RS-485, 0 = RS-232
    } cfg_t;

endpackage

// File: rtl/xcvr_dir_regs.sv
module xcvr_dir_regs
    import xcvr_dir_pkg::*;
#(
    parameter int unsigned CAP       = 3,
    parameter int unsigned TX_DEPTH  = 128,
    parameter int unsigned RX_DEPTH  = 64,
    parameter bit          IFACE_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output cfg_t          cfg
);

    localparam logic [1:0]    CAP_BITS = CAP[1:0];
    localparam logic [DW-1:0] TX_BYTE  = TX_DEPTH[DW-1:0];
    localparam logic [DW-1:0] RX_BYTE  = RX_DEPTH[DW-1:0];
    localparam bit            IS_DUAL  = (CAP_BITS == 2'd3);
    localparam logic          IFACE_INIT =
        (CAP_BITS == 2'd1) ? 1'b0 :
        (CAP_BITS == 2'd3) ? IFACE_RST : 1'b1;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && addr == OFS_CTRL) begin
            cfg_d.mode   = wire_mode_e'(wdata[1:0]);
            cfg_d.master = wdata[3];
            cfg_d.term   = wdata[6];
        end
        if (wr_en && addr == OFS_MODE && IS_DUAL) begin
            cfg_d.iface = wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: WM_AUTO, master: 1'b0, term: 1'b0, iface: IFACE_INIT};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_TXSZ: rdata = TX_BYTE;
            OFS_RXSZ: rdata = RX_BYTE;
            OFS_MODE: rdata = {3'b000, cfg_q.iface, 2'b00, CAP_BITS};
            OFS_CTRL: rdata = {1'b0, cfg_q.term, 2'b00, cfg_q.master, 1'b0, cfg_q.mode};
            default:  rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    AST_IFACE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_DUAL |=> $stable(cfg_q.iface)); // R8

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=> (cfg_q.master == $past(wdata[3]))); // R11

endmodule

// File: rtl/xcvr_dir_gate.sv
module xcvr_dir_gate
    import xcvr_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic dtr,
    input  logic tx_busy,
    output logic tx_en,
    output logic rx_en,
    output logic term_en
);

    typedef struct packed {
        logic txe;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     tx_want;
    logic     half_dup;

    always_comb begin
        st_d     = st_q;
        half_dup = cfg.iface && (cfg.mode == WM_DTR || cfg.mode == WM_AUTO);
        tx_want  = 1'b1;
        if (cfg.iface) begin
            unique case (cfg.mode)
                WM_FULL: tx_want = 1'b1;
                WM_ECHO: tx_want = dtr;
                WM_DTR:  tx_want = dtr;
                WM_AUTO: tx_want = tx_busy;
                default: tx_want = 1'b0;
            endcase
        end
        tx_en    = cfg.master && tx_want;
        rx_en    = cfg.master && (!half_dup || (!tx_en && !st_q.txe));
        st_d.txe = tx_en;
        term_en  = cfg.term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{txe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.master |-> (!tx_en && !rx_en)); // R6

    AST_AUTO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.master && cfg.iface && cfg.mode == WM_AUTO) |-> (tx_en == tx_busy)); // R5

    AST_HALF_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.master && cfg.iface && cfg.mode == WM_DTR && $past(tx_en)) |-> !rx_en); // R4

    AST_NO_TALK_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.iface && (cfg.mode == WM_DTR || cfg.mode == WM_AUTO)) |-> !(tx_en && rx_en)); // R5

    AST_RS232_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.master && !cfg.iface) |-> (tx_en && rx_en)); // R10

endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_dir_pkg::*;
#(
    parameter int unsigned CAP       = 3,
    parameter int unsigned TX_DEPTH  = 128,
    parameter int unsigned RX_DEPTH  = 64,
    parameter bit          IFACE_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       dtr,
    input  logic       tx_busy,
    output logic       tx_en,
    output logic       rx_en,
    output logic       term_en
);

    cfg_t cfg;

    xcvr_dir_regs #(
        .CAP       (CAP),
        .TX_DEPTH  (TX_DEPTH),
        .RX_DEPTH  (RX_DEPTH),
        .IFACE_RST (IFACE_RST)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    xcvr_dir_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .dtr     (dtr),
        .tx_busy (tx_busy),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .term_en (term_en)
    );

    AST_TERM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        term_en == rdata[6] || addr != 4'hF); // R7

endmodule

// File: tb/xcvr_dir_ctrl_bench.sv
module xcvr_dir_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       dtr = 1'b0;
    logic       tx_busy = 1'b0;
    logic       tx_en, rx_en, term_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    xcvr_dir_ctrl #(.CAP(3), .TX_DEPTH(128), .RX_DEPTH(64), .IFACE_RST(1'b1)) u_xcvr_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dtr(dtr), .tx_busy(tx_busy),
        .tx_en(tx_en), .rx_en(rx_en), .term_en(term_en)
    );

    // Expected item layout: {tx_en, rx_en, term_en, rdata}
    typedef struct {
        string       req;
        logic [10:0] exp;
        logic [10:0] msk;
    } item_t;

    item_t sb[$];

    localparam logic [10:0] M_TXRX = 11'b110_0000_0000;
    localparam logic [10:0] M_TERM = 11'b001_0000_0000;
    localparam logic [10:0] M_RD   = 11'b000_1111_1111;
    localparam logic [10:0] M_ALL  = 11'b111_1111_1111;

    task automatic push(input string r, input logic [10:0] e, input logic [10:0] m);
        item_t it;
        it.req = r; it.exp = e; it.msk = m;
        sb.push_back(it);
    endtask

    // Driver: step to a falling edge, set inputs, queue expectations.
    task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                        input logic dt, input logic bz);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; dtr = dt; tx_busy = bz;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(1'b1, a, d, dtr, tx_busy);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compares queued items shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [10:0] act;
                it  = sb.pop_front();
                act = {tx_en, rx_en, term_en, rdata};
                n_vec++;
                if ((act & it.msk) !== (it.exp & it.msk)) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b (mask %b)", it.req, act, it.exp, it.msk);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R1", {3'b000, 8'h03}, M_ALL);
        // R8 mode register after reset
        step(1'b0, 4'hE, 8'h00, 1'b0, 1'b0);
        push("R8", {3'b000, 8'h13}, M_RD);
        // R9 depth registers and an empty offset
        step(1'b0, 4'hC, 8'h00, 1'b0, 1'b0);
        push("R9", {3'b000, 8'h80}, M_RD);
        step(1'b0, 4'hD, 8'h00, 1'b0, 1'b0);
        push("R9", {3'b000, 8'h40}, M_RD);
        step(1'b0, 4'h5, 8'h00, 1'b0, 1'b0);
        push("R9", {3'b000, 8'h00}, M_RD);
        wr(4'hC, 8'h11);
        addr = 4'hC;
        push("R9", {3'b000, 8'h80}, M_RD);
        // R11 unused control bits read 0, R7 termination
        wr(4'hF, 8'hFF);
        addr = 4'hF;
        push("R11", {3'b000, 8'h4B}, M_RD);
        push("R7", {3'b001, 8'h00}, M_TERM);
        // R5 automatic mode: idle, busy, fall, recover
        push("R5", {3'b010, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b1);
        push("R5", {3'b100, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R5", {3'b000, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R5", {3'b010, 8'h00}, M_TXRX);
        // R2 full duplex
        wr(4'hF, 8'h08);
        push("R2", {3'b110, 8'h00}, M_TXRX);
        push("R7", {3'b000, 8'h00}, M_TERM);
        step(1'b0, 4'hF, 8'h00, 1'b1, 1'b1);
        push("R2", {3'b110, 8'h00}, M_TXRX);
        // R3 echo mode
        wr(4'hF, 8'h09);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R3", {3'b010, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b1, 1'b0);
        push("R3", {3'b110, 8'h00}, M_TXRX);
        // R4 DTR keyed half duplex
        wr(4'hF, 8'h0A);
        push("R4", {3'b100, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R4", {3'b000, 8'h00}, M_TXRX);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
        push("R4", {3'b010, 8'h00}, M_TXRX);
        // R6 master off
        wr(4'hF, 8'h03);
        step(1'b0, 4'hF, 8'h00, 1'b1, 1'b1);
        push("R6", {3'b000, 8'h00}, M_TXRX);
        wr(4'hF, 8'h00);
        push("R6", {3'b000, 8'h00}, M_TXRX);
        // Same cycle: busy falls while the mode changes from automatic to DTR keyed
        wr(4'hF, 8'h0B);
        step(1'b0, 4'hF, 8'h00, 1'b0, 1'b1);
        push("R5", {3'b100, 8'h00}, M_TXRX);
        step(1'b1, 4'hF, 8'h0A, 1'b0, 1'b0);
        push("R5", {3'b000, 8'h00}, M_TXRX);
        @(negedge clk);
        wr_en = 1'b0;
        push("R4", {3'b010, 8'h00}, M_TXRX);
        // R8 interface mode write, R10 RS-232 bypass
        wr(4'hE, 8'h00);
        addr = 4'hE;
        push("R8", {3'b000, 8'h03}, M_RD);
        wr(4'hF, 8'h0B);
        push("R10", {3'b110, 8'h00}, M_TXRX);
        wr(4'hF, 8'h0A);
        push("R10", {3'b110, 8'h00}, M_TXRX);
        wr(4'hE, 8'h13);
        addr = 4'hE;
        push("R8", {3'b000, 8'h13}, M_RD);

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule